// File: doc/BRIEF.md
# Lane Alignment Sequence Monitor

This block watches one serial lane on the receive side during link start-up. Each link clock it takes a 32-bit word made of four octets, with octet 0 in bits [7:0] first in time, and a 4-bit flag vector that marks which octets are control characters (flag bit j belongs to octet j). It hunts for the first multiframe start marker. It then follows four multiframes of a fixed length and checks that every start, end and configuration marker sits exactly where it belongs.

During the second multiframe it captures the 14 link-configuration octets that follow the configuration marker. It compares each one with an expected value supplied on a port and stores the octets so they can be read back as 32-bit words. Two status outputs report frame alignment and full lane alignment. Two sticky error bits, one for sequence errors and one for configuration mismatches, are cleared by a write-one-to-clear strobe. A maskable interrupt line is the OR of the enabled error bits.

Multiframes are assumed to start on word boundaries (MF_OCTETS is a multiple of four). After lane alignment the block enters a data phase and performs no further marker checks until reset.

Top module: `lane_align_monitor`

## Requirements
- R1: After reset, frame_lock, lane_lock, err_flags, irq and cfg_rd_data are all zero.
- R2: While hunting, only a word whose octet 0 is a flagged 0x1C starts alignment, and frame_lock rises at the next clock edge. Flagged 0x1C octets in other positions, and all other words, leave the block hunting.
- R3: Each multiframe spans MF_OCTETS octets (default 32, which is 8 words). It must begin with a flagged 0x1C at its first octet and end with a flagged 0x7C at its last octet. A missing marker, or a flagged 0x1C or 0x7C anywhere else, is a sequence error.
- R4: In the second multiframe, a flagged 0x9C must sit at octet position 1, directly after the start marker. Its absence there, or a flagged 0x9C at any other position during alignment, is a sequence error.
- R5: lane_lock rises at the clock edge after the last word of the fourth multiframe, provided no error occurred. After that the data phase begins: markers are no longer checked, and both locks hold until reset.
- R6: A sequence error sets err_flags[0] and clears frame_lock and lane_lock at the next edge. The block then hunts again, starting with the following word.
- R7: Octets at positions 2 to 15 of the second multiframe are stored as configuration octets 0 to 13. Driving cfg_rd_sel = k returns, one cycle later, octet 4k+j in cfg_rd_data bits [8j+7:8j]. Octet slots beyond 13 read as zero.
- R8: If a captured octet i differs from exp_cfg bits [8i+7:8i], err_flags[1] is set at the edge after the word that carried it. Alignment continues, and the mismatch alone does not drop the locks.
- R9: Error bits stay set until a 1 is written on the matching bit of err_clr. When a clear and a new error hit the same bit in the same cycle, the bit stays set.
- R10: irq is registered and equals the OR of err_flags ANDed with irq_en. It is low whenever no error bit is set.
- R11: Octets whose flag bit is 0 are treated as plain data, even when they hold the values 0x1C, 0x7C or 0x9C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_data | input | 32 | Four received octets, octet 0 in bits [7:0] |
| lane_ctrl | input | 4 | Control-character flag per octet |
| exp_cfg | input | 112 | Expected configuration octets, octet i at [8i+7:8i] |
| irq_en | input | 2 | Interrupt enable per error bit |
| err_clr | input | 2 | Write-one-to-clear strobe per error bit |
| cfg_rd_sel | input | 2 | Captured configuration word select |
| cfg_rd_data | output | 32 | Selected configuration word, one cycle latency |
| frame_lock | output | 1 | Frame alignment found |
| lane_lock | output | 1 | Four-multiframe sequence received correctly |
| err_flags | output | 2 | Bit 0 sequence error, bit 1 configuration mismatch |
| irq | output | 1 | Interrupt request |

## Verification
The error register can receive a new error from the lane and a software clear on the same bit in the same cycle. To provoke this, the bench first sets the sequence-error bit, then presents a malformed start word while pulsing the clear strobe. The bit must still read 1 afterwards, and a lone clear must then drop it. A configuration mismatch also arrives in the same cycle as the alignment tracker advances its position. The bench judges that collision by requiring the mismatch flag and the interrupt on the exact word that carried the bad octet, while lane_lock still rises at the end of the sequence.

// File: rtl/lam_pkg.sv
package lam_pkg;
  localparam logic [7:0] MK_START = 8'h1C;
  localparam logic [7:0] MK_END   = 8'h7C;
  localparam logic [7:0] MK_CFG   = 8'h9C;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_ALIGN = 2'd1,
    ST_DATA  = 2'd2
  } lam_state_e;
endpackage

// File: rtl/lam_octet_classify.sv
module lam_octet_classify #(
  parameter int OPW = 4
) (
  input  logic [OPW*8-1:0] lane_data,
  input  logic [OPW-1:0]   lane_ctrl,
  output logic [OPW-1:0]   is_start,
  output logic [OPW-1:0]   is_end,
  output logic [OPW-1:0]   is_cfg
);
  import lam_pkg::*;

  for (genvar j = 0; j < OPW; j++) begin : g_oct
    assign is_start[j] = lane_ctrl[j] && (lane_data[8*j +: 8] == MK_START);
    assign is_end[j]   = lane_ctrl[j] && (lane_data[8*j +: 8] == MK_END);
    assign is_cfg[j]   = lane_ctrl[j] && (lane_data[8*j +: 8] == MK_CFG);
  end
endmodule

// File: rtl/lam_seq_tracker.sv
module lam_seq_tracker #(
  parameter int OPW       = 4,
  parameter int MF_OCTETS = 32,
  parameter int MF_NUM    = 4
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic [OPW-1:0]                           is_start,
  input  logic [OPW-1:0]                           is_end,
  input  logic [OPW-1:0]                           is_cfg,
  output logic                                     cap_en,
  output logic [$clog2(MF_OCTETS/OPW)-1:0]         cap_word,
  output logic                                     seq_bad,
  output logic                                     frame_lock,
  output logic                                     lane_lock
);
  import lam_pkg::*;

  localparam int WPM    = MF_OCTETS / OPW;
  localparam int WIDX_W = $clog2(WPM);
  localparam int MF_W   = (MF_NUM > 1) ? $clog2(MF_NUM) : 1;

  lam_state_e        state_q;
  logic [WIDX_W-1:0] word_q;
  logic [MF_W-1:0]   mf_q;

  logic              active;
  logic              bad;
  logic [WIDX_W-1:0] cur_w;
  logic [MF_W-1:0]   cur_mf;
  logic              last_w;
  logic              last_mf;

  always_comb begin
    active = (state_q == ST_ALIGN) || ((state_q == ST_HUNT) && is_start[0]);
    cur_w  = (state_q == ST_ALIGN) ? word_q : '0;
    cur_mf = (state_q == ST_ALIGN) ? mf_q : '0;
    bad    = 1'b0;
    for (int j = 0; j < OPW; j++) begin
      int p;
      p = int'(cur_w) * OPW + j;
      if (is_start[j] != (p == 0)) bad = 1'b1;
      if (is_end[j] != (p == MF_OCTETS - 1)) bad = 1'b1;
      if (is_cfg[j] != ((int'(cur_mf) == 1) && (p == 1))) bad = 1'b1;
    end
    seq_bad  = active && bad;
    last_w   = (cur_w == WIDX_W'(WPM - 1));
    last_mf  = (cur_mf == MF_W'(MF_NUM - 1));
    cap_en   = active && (int'(cur_mf) == 1);
    cap_word = cur_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_HUNT;
      word_q     <= '0;
      mf_q       <= '0;
      frame_lock <= 1'b0;
      lane_lock  <= 1'b0;
    end else if (seq_bad) begin
      state_q    <= ST_HUNT;
      word_q     <= '0;
      mf_q       <= '0;
      frame_lock <= 1'b0;
      lane_lock  <= 1'b0;
    end else if (active) begin
      frame_lock <= 1'b1;
      if (last_w) begin
        word_q <= '0;
        if (last_mf) begin
          state_q   <= ST_DATA;
          lane_lock <= 1'b1;
          mf_q      <= cur_mf;
        end else begin
          state_q <= ST_ALIGN;
          mf_q    <= cur_mf + 1'b1;
        end
      end else begin
        state_q <= ST_ALIGN;
        word_q  <= cur_w + 1'b1;
        mf_q    <= cur_mf;
      end
    end
  end

  // R5: full lane alignment never stands without frame alignment
  assert_lane_needs_frame_R5: assert property (@(posedge clk) disable iff (rst)
    lane_lock |-> frame_lock);

  // R5: once in the data phase the block stays there with lane lock held
  assert_data_phase_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DATA) |=> ((state_q == ST_DATA) && lane_lock));

  // R6: a sequence error drops both locks at the next edge
  assert_error_drops_locks_R6: assert property (@(posedge clk) disable iff (rst)
    seq_bad |=> (!lane_lock && !frame_lock));
endmodule

// File: rtl/lam_cfg_store.sv
module lam_cfg_store #(
  parameter int OPW        = 4,
  parameter int MF_OCTETS  = 32,
  parameter int CFG_OCTETS = 14,
  parameter int CFG_POS    = 2
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 cap_en,
  input  logic [$clog2(MF_OCTETS/OPW)-1:0]     cap_word,
  input  logic [OPW*8-1:0]                     lane_data,
  input  logic [CFG_OCTETS*8-1:0]              exp_cfg,
  input  logic [((CFG_OCTETS+OPW-1)/OPW > 1 ? $clog2((CFG_OCTETS+OPW-1)/OPW) : 1)-1:0] rd_sel,
  output logic                                 cfg_mis,
  output logic [OPW*8-1:0]                     rd_data
);
  localparam int IDX_W = (CFG_OCTETS > 1) ? $clog2(CFG_OCTETS) : 1;

  logic [7:0] oct_mem [CFG_OCTETS];
  logic [7:0] exp_oct [CFG_OCTETS];
  logic [OPW*8-1:0] rd_word;

  for (genvar i = 0; i < CFG_OCTETS; i++) begin : g_exp
    assign exp_oct[i] = exp_cfg[8*i +: 8];
  end

  always_comb begin
    cfg_mis = 1'b0;
    for (int j = 0; j < OPW; j++) begin
      int p;
      p = int'(cap_word) * OPW + j;
      if (cap_en && (p >= CFG_POS) && (p < CFG_POS + CFG_OCTETS)) begin
        if (lane_data[8*j +: 8] != exp_oct[IDX_W'(p - CFG_POS)]) cfg_mis = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CFG_OCTETS; i++) oct_mem[i] <= 8'h00;
    end else begin
      for (int j = 0; j < OPW; j++) begin
        int p;
        p = int'(cap_word) * OPW + j;
        if (cap_en && (p >= CFG_POS) && (p < CFG_POS + CFG_OCTETS))
          oct_mem[IDX_W'(p - CFG_POS)] <= lane_data[8*j +: 8];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int j = 0; j < OPW; j++) begin
      int idx;
      idx = int'(rd_sel) * OPW + j;
      if (idx < CFG_OCTETS) rd_word[8*j +: 8] = oct_mem[IDX_W'(idx)];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_word;
  end
endmodule

// File: rtl/lane_align_monitor.sv
module lane_align_monitor #(
  parameter int OPW        = 4,
  parameter int MF_OCTETS  = 32,
  parameter int MF_NUM     = 4,
  parameter int CFG_OCTETS = 14,
  parameter int CFG_WORDS  = (CFG_OCTETS + OPW - 1) / OPW,
  parameter int SEL_W      = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [OPW*8-1:0]        lane_data,
  input  logic [OPW-1:0]          lane_ctrl,
  input  logic [CFG_OCTETS*8-1:0] exp_cfg,
  input  logic [1:0]              irq_en,
  input  logic [1:0]              err_clr,
  input  logic [SEL_W-1:0]        cfg_rd_sel,
  output logic [OPW*8-1:0]        cfg_rd_data,
  output logic                    frame_lock,
  output logic                    lane_lock,
  output logic [1:0]              err_flags,
  output logic                    irq
);
  localparam int WIDX_W = $clog2(MF_OCTETS / OPW);

  logic [OPW-1:0]    is_start, is_end, is_cfg;
  logic              cap_en, seq_bad, cfg_mis;
  logic [WIDX_W-1:0] cap_word;
  logic [1:0]        err_d;

  lam_octet_classify #(.OPW(OPW)) u_classify (
    .lane_data (lane_data),
    .lane_ctrl (lane_ctrl),
    .is_start  (is_start),
    .is_end    (is_end),
    .is_cfg    (is_cfg)
  );

  lam_seq_tracker #(.OPW(OPW), .MF_OCTETS(MF_OCTETS), .MF_NUM(MF_NUM)) u_tracker (
    .clk        (clk),
    .rst        (rst),
    .is_start   (is_start),
    .is_end     (is_end),
    .is_cfg     (is_cfg),
    .cap_en     (cap_en),
    .cap_word   (cap_word),
    .seq_bad    (seq_bad),
    .frame_lock (frame_lock),
    .lane_lock  (lane_lock)
  );

  lam_cfg_store #(.OPW(OPW), .MF_OCTETS(MF_OCTETS), .CFG_OCTETS(CFG_OCTETS), .CFG_POS(2)) u_store (
    .clk       (clk),
    .rst       (rst),
    .cap_en    (cap_en),
    .cap_word  (cap_word),
    .lane_data (lane_data),
    .exp_cfg   (exp_cfg),
    .rd_sel    (cfg_rd_sel),
    .cfg_mis   (cfg_mis),
    .rd_data   (cfg_rd_data)
  );

  // new error events take priority over a clear in the same cycle
  assign err_d = (err_flags & ~err_clr) | {cfg_mis, seq_bad};

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flags <= 2'b00;
      irq       <= 1'b0;
    end else begin
      err_flags <= err_d;
      irq       <= |(err_d & irq_en);
    end
  end

  // R9: sequence error bit is sticky without a clear
  assert_seq_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (err_flags[0] && !err_clr[0]) |=> err_flags[0]);

  // R9: mismatch bit is sticky without a clear
  assert_cfg_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (err_flags[1] && !err_clr[1]) |=> err_flags[1]);

  // R10: no interrupt while no error bit is set
  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (err_flags == 2'b00) |-> !irq);
endmodule

// File: tb/lane_align_monitor_test.sv
`timescale 1ns/1ps
module lane_align_monitor_test;
  localparam int WPM   = 8;
  localparam int NWORD = 4 * WPM;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [31:0]  lane_data = 32'hBCBCBCBC;
  logic [3:0]   lane_ctrl = 4'hF;
  logic [111:0] exp_cfg = '0;
  logic [1:0]   irq_en = 2'b11;
  logic [1:0]   err_clr = 2'b00;
  logic [1:0]   cfg_rd_sel = 2'd0;
  logic [31:0]  cfg_rd_data;
  logic         frame_lock, lane_lock, irq;
  logic [1:0]   err_flags;

  int total = 0;
  int bad = 0;

  localparam logic [111:0] CFG_A = 112'h8C7B6A5948372615F4E3D2C1B0A9;

  always #2.5 clk = ~clk;

  lane_align_monitor uut (
    .clk(clk), .rst(rst), .lane_data(lane_data), .lane_ctrl(lane_ctrl),
    .exp_cfg(exp_cfg), .irq_en(irq_en), .err_clr(err_clr), .cfg_rd_sel(cfg_rd_sel),
    .cfg_rd_data(cfg_rd_data), .frame_lock(frame_lock), .lane_lock(lane_lock),
    .err_flags(err_flags), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  // drive one word, return at the next falling edge with outputs updated
  task automatic put(input logic [31:0] d, input logic [3:0] k);
    lane_data = d;
    lane_ctrl = k;
    @(negedge clk);
  endtask

  task automatic idle();
    put(32'hBCBCBCBC, 4'hF);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    err_clr = 2'b00;
    cfg_rd_sel = 2'd0;
    lane_data = 32'hBCBCBCBC;
    lane_ctrl = 4'hF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // flt: 0 clean, 1 drop config marker, 2 drop end marker of first
  // multiframe, 3 extra config marker in third multiframe
  function automatic logic [35:0] mk_word(int mf, int w, logic [111:0] cfg, int flt);
    logic [31:0] d;
    logic [3:0]  k;
    d = '0;
    k = '0;
    for (int j = 0; j < 4; j++) begin
      int p;
      p = w * 4 + j;
      if (p == 0) begin
        d[8*j +: 8] = 8'h1C; k[j] = 1'b1;
      end else if (p == 31 && !(flt == 2 && mf == 0)) begin
        d[8*j +: 8] = 8'h7C; k[j] = 1'b1;
      end else if (mf == 1 && p == 1 && flt != 1) begin
        d[8*j +: 8] = 8'h9C; k[j] = 1'b1;
      end else if (mf == 2 && p == 1 && flt == 3) begin
        d[8*j +: 8] = 8'h9C; k[j] = 1'b1;
      end else if (mf == 1 && p >= 2 && p < 16) begin
        d[8*j +: 8] = cfg[8*(p-2) +: 8];
      end else if (p == 5) begin
        d[8*j +: 8] = 8'h9C;
      end else if (p == 6) begin
        d[8*j +: 8] = 8'h1C;
      end else if (p == 7) begin
        d[8*j +: 8] = 8'h7C;
      end else begin
        d[8*j +: 8] = 8'(p + 8'h40);
      end
    end
    return {k, d};
  endfunction

  task automatic send_seq(input logic [111:0] cfg, input int flt, input int first, input int last);
    for (int i = first; i <= last; i++) begin
      logic [35:0] wk;
      wk = mk_word(i / WPM, i % WPM, cfg, flt);
      put(wk[31:0], wk[35:32]);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 frame_lock", {31'b0, frame_lock}, 32'd0);
    chk("R1 lane_lock", {31'b0, lane_lock}, 32'd0);
    chk("R1 err_flags", {30'b0, err_flags}, 32'd0);
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 cfg_rd_data", cfg_rd_data, 32'd0);
  endtask

  task automatic t_good();
    logic [127:0] c128;
    do_reset();
    exp_cfg = CFG_A;
    irq_en = 2'b11;
    idle();
    chk("R2 idle keeps hunting", {31'b0, frame_lock}, 32'd0);
    put(32'h001C0000, 4'b0100);
    chk("R2 start marker off octet 0 ignored", {31'b0, frame_lock}, 32'd0);
    put(32'h0000001C, 4'b0000);
    chk("R11 unflagged start value ignored", {31'b0, frame_lock}, 32'd0);
    send_seq(CFG_A, 0, 0, 0);
    chk("R2 frame_lock after start", {31'b0, frame_lock}, 32'd1);
    chk("R2 no lane_lock yet", {31'b0, lane_lock}, 32'd0);
    send_seq(CFG_A, 0, 1, NWORD - 2);
    chk("R5 lane_lock before last word", {31'b0, lane_lock}, 32'd0);
    chk("R11 unflagged marker values are data", {30'b0, err_flags}, 32'd0);
    send_seq(CFG_A, 0, NWORD - 1, NWORD - 1);
    chk("R5 lane_lock after fourth multiframe", {31'b0, lane_lock}, 32'd1);
    chk("R3 clean sequence no error", {30'b0, err_flags}, 32'd0);
    chk("R10 irq low without error", {31'b0, irq}, 32'd0);
    c128 = {16'h0, CFG_A};
    for (int k = 0; k < 4; k++) begin
      cfg_rd_sel = 2'(k);
      idle();
      chk($sformatf("R7 config word %0d", k), cfg_rd_data, c128[32*k +: 32]);
    end
    put(32'h7C1C9C1C, 4'hF);
    put(32'h00009C00, 4'b0010);
    chk("R5 data phase holds lane_lock", {31'b0, lane_lock}, 32'd1);
    chk("R5 data phase no checks", {30'b0, err_flags}, 32'd0);
  endtask

  task automatic t_mismatch();
    logic [111:0] bad_cfg;
    do_reset();
    exp_cfg = CFG_A;
    irq_en = 2'b11;
    bad_cfg = CFG_A ^ (112'h5A << (13 * 8));
    send_seq(bad_cfg, 0, 0, 10);
    chk("R8 no mismatch before bad octet", {30'b0, err_flags}, 32'd0);
    send_seq(bad_cfg, 0, 11, 11);
    chk("R8 mismatch flag on bad octet", {30'b0, err_flags}, 32'd2);
    chk("R10 irq with mismatch", {31'b0, irq}, 32'd1);
    send_seq(bad_cfg, 0, 12, NWORD - 1);
    chk("R8 mismatch keeps lane_lock", {31'b0, lane_lock}, 32'd1);
    cfg_rd_sel = 2'd3;
    idle();
    chk("R7 captured word holds received octet", cfg_rd_data, {16'h0, bad_cfg[111:96]});
    chk("R9 mismatch sticky", {30'b0, err_flags}, 32'd2);
    err_clr = 2'b10;
    idle();
    err_clr = 2'b00;
    chk("R9 clear mismatch", {30'b0, err_flags}, 32'd0);
    chk("R10 irq drops after clear", {31'b0, irq}, 32'd0);
  endtask

  task automatic t_mask();
    do_reset();
    exp_cfg = ~CFG_A;
    irq_en = 2'b00;
    send_seq(CFG_A, 0, 0, NWORD - 1);
    chk("R10 masked error bit set", {30'b0, err_flags}, 32'd2);
    chk("R10 masked irq low", {31'b0, irq}, 32'd0);
    irq_en = 2'b10;
    idle();
    chk("R10 enable raises irq", {31'b0, irq}, 32'd1);
    irq_en = 2'b11;
  endtask

  task automatic t_missing_cfg_marker();
    do_reset();
    exp_cfg = CFG_A;
    send_seq(CFG_A, 1, 0, 7);
    chk("R4 first multiframe clean", {30'b0, err_flags}, 32'd0);
    chk("R4 frame_lock held", {31'b0, frame_lock}, 32'd1);
    send_seq(CFG_A, 1, 8, 8);
    chk("R4 missing config marker", {30'b0, err_flags}, 32'd1);
    chk("R6 frame_lock cleared", {31'b0, frame_lock}, 32'd0);
    chk("R6 irq on sequence error", {31'b0, irq}, 32'd1);
  endtask

  task automatic t_stray_cfg_marker();
    do_reset();
    exp_cfg = CFG_A;
    send_seq(CFG_A, 3, 0, 15);
    chk("R4 two multiframes clean", {30'b0, err_flags}, 32'd0);
    send_seq(CFG_A, 3, 16, 16);
    chk("R4 config marker in third multiframe", {30'b0, err_flags}, 32'd1);
    send_seq(CFG_A, 3, 17, NWORD - 1);
    chk("R6 no lane_lock after error", {31'b0, lane_lock}, 32'd0);
  endtask

  task automatic t_missing_end_and_set_wins();
    do_reset();
    exp_cfg = CFG_A;
    send_seq(CFG_A, 2, 0, 6);
    chk("R3 before end position", {30'b0, err_flags}, 32'd0);
    send_seq(CFG_A, 2, 7, 7);
    chk("R3 missing end marker", {30'b0, err_flags}, 32'd1);
    err_clr = 2'b01;
    put(32'h00007C1C, 4'b0011);
    err_clr = 2'b00;
    chk("R9 set wins over clear", {30'b0, err_flags}, 32'd1);
    chk("R3 stray end marker after start", {31'b0, frame_lock}, 32'd0);
    err_clr = 2'b01;
    idle();
    err_clr = 2'b00;
    chk("R9 lone clear", {30'b0, err_flags}, 32'd0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_good();
        t_mismatch();
        t_mask();
        t_missing_cfg_marker();
        t_stray_cfg_marker();
        t_missing_end_and_set_wins();
      end
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=timeout exp=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule